// File: doc/BRIEF.md
# Multi-Operand Prefix-Sum Unit

This block keeps a small set of shared accumulator registers and serves atomic fetch-and-add requests against them from many requesters at once. Each requester may raise a request in any cycle. A request names one accumulator and carries an increment. Every request that names the same accumulator in the same cycle is folded into one multi-operand update. The accumulator gains the sum of all those increments in a single clock. Each requester receives a distinct running partial sum: the accumulator's value just before its own contribution. Requesters are ranked by ascending index inside a cycle, so the lowest-numbered requester sees the untouched accumulator.

A control port lets a master load any accumulator and read any accumulator back. A load issued in the same cycle as requests to the same accumulator is applied first, and those requests then build on the loaded value. Results are registered. They come back one clock after the request, each with its own valid flag.

Top module: `psum_unit`

## Requirements
- R1: While reset (rst_n low) is asserted, and after it is released, all accumulators read zero and every rsp_valid bit is low.
- R2: A lone request with increment L to accumulator k returns, on rsp_old one clock later, the value k held before. After the clock edge, k holds that value plus L.
- R3: Requests to the same accumulator in one cycle are ranked by ascending requester index. Requester i receives the accumulator value plus the increments of all lower-indexed valid requesters naming that accumulator.
- R4: After a cycle of requests, each accumulator equals its prior value plus the sum of the increments of all valid requests naming it.
- R5: Requests naming different accumulators do not interact. Neither the returned values nor the updates of one accumulator depend on requests to another.
- R6: rsp_valid[i] is high exactly one clock after req_valid[i] was high. The increment of a requester whose req_valid is low has no effect on any accumulator or on any other requester's result.
- R7: All arithmetic wraps modulo 2^WIDTH, with no overflow indication.
- R8: A master load (mst_wr_en high) of accumulator k in a cycle takes effect before that cycle's requests. Requests to k in the same cycle see the loaded value, and k ends at that value plus their increments.
- R9: mst_rdata shows, without delay, the current registered value of the accumulator selected by mst_rd_idx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NREQ | Per-requester request strobe |
| req_base | input | NREQ*IW | Per-requester accumulator index, requester i in bits [i*IW +: IW] |
| req_inc | input | NREQ*WIDTH | Per-requester increment, requester i in bits [i*WIDTH +: WIDTH] |
| mst_wr_en | input | 1 | Master load strobe |
| mst_wr_idx | input | IW | Accumulator index to load |
| mst_wdata | input | WIDTH | Value to load |
| mst_rd_idx | input | IW | Accumulator index to read |
| mst_rdata | output | WIDTH | Current value of the selected accumulator |
| rsp_valid | output | NREQ | Per-requester result strobe, one clock after the request |
| rsp_old | output | NREQ*WIDTH | Per-requester pre-contribution value, same packing as req_inc |

## Verification
Accumulator state is held only in the registers behind mst_rdata, so any wrong internal sum shows on a master read in the same cycle it is committed. It also shows one clock later in the rsp_old value of the next request to that accumulator. A ranking or combining error shows in the very next clock as two requesters with equal or out-of-order partial sums. The sweep runs every mask of active requesters over varied accumulator mappings. It also reads back all accumulators after each cycle, so a corrupted value cannot stay hidden for more than one clock.

// File: rtl/psum_pkg.sv
package psum_pkg;
    localparam int DEF_NREQ  = 8;
    localparam int DEF_NBASE = 4;
    localparam int DEF_WIDTH = 32;
endpackage

// File: rtl/psum_scan.sv
// Combines same-cycle requests: per-requester offset within its accumulator
// group (ascending index) and per-accumulator total increment.
module psum_scan #(
    parameter int NREQ  = 8,
    parameter int NBASE = 4,
    parameter int WIDTH = 32,
    localparam int IW   = (NBASE > 1) ? $clog2(NBASE) : 1
) (
    input  logic [NREQ-1:0]        valid,
    input  logic [NREQ*IW-1:0]     sel,
    input  logic [NREQ*WIDTH-1:0]  inc,
    output logic [NREQ*WIDTH-1:0]  offset,
    output logic [NBASE*WIDTH-1:0] total
);
    logic [WIDTH-1:0] run [NBASE];

    always_comb begin
        for (int b = 0; b < NBASE; b++) begin
            run[b] = '0;
        end
        offset = '0;
        for (int i = 0; i < NREQ; i++) begin
            offset[i*WIDTH +: WIDTH] = run[sel[i*IW +: IW]];
            if (valid[i]) begin
                run[sel[i*IW +: IW]] = run[sel[i*IW +: IW]] + inc[i*WIDTH +: WIDTH];
            end
        end
        for (int b = 0; b < NBASE; b++) begin
            total[b*WIDTH +: WIDTH] = run[b];
        end
    end
endmodule

// File: rtl/psum_bank.sv
// Accumulator registers; a master load overrides the pre-add value.
module psum_bank #(
    parameter int NBASE = 4,
    parameter int WIDTH = 32,
    localparam int IW   = (NBASE > 1) ? $clog2(NBASE) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IW-1:0]          wr_idx,
    input  logic [WIDTH-1:0]       wr_data,
    input  logic [NBASE*WIDTH-1:0] total,
    output logic [NBASE*WIDTH-1:0] eff,
    output logic [NBASE*WIDTH-1:0] q
);
    for (genvar b = 0; b < NBASE; b++) begin : g_acc
        always_comb begin
            if (wr_en && (int'(wr_idx) == b)) begin
                eff[b*WIDTH +: WIDTH] = wr_data;
            end else begin
                eff[b*WIDTH +: WIDTH] = q[b*WIDTH +: WIDTH];
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[b*WIDTH +: WIDTH] <= '0;
            end else begin
                q[b*WIDTH +: WIDTH] <= eff[b*WIDTH +: WIDTH] + total[b*WIDTH +: WIDTH];
            end
        end
    end
endmodule

// File: rtl/psum_unit.sv
module psum_unit #(
    parameter int NREQ  = psum_pkg::DEF_NREQ,
    parameter int NBASE = psum_pkg::DEF_NBASE,
    parameter int WIDTH = psum_pkg::DEF_WIDTH,
    localparam int IW   = (NBASE > 1) ? $clog2(NBASE) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NREQ-1:0]       req_valid,
    input  logic [NREQ*IW-1:0]    req_base,
    input  logic [NREQ*WIDTH-1:0] req_inc,
    input  logic                  mst_wr_en,
    input  logic [IW-1:0]         mst_wr_idx,
    input  logic [WIDTH-1:0]      mst_wdata,
    input  logic [IW-1:0]         mst_rd_idx,
    output logic [WIDTH-1:0]      mst_rdata,
    output logic [NREQ-1:0]       rsp_valid,
    output logic [NREQ*WIDTH-1:0] rsp_old
);
    logic [NREQ*WIDTH-1:0]  offset;
    logic [NBASE*WIDTH-1:0] total;
    logic [NBASE*WIDTH-1:0] eff;
    logic [NBASE*WIDTH-1:0] base_q;
    logic [WIDTH-1:0]       eff_arr [NBASE];
    logic [WIDTH-1:0]       q_arr   [NBASE];

    psum_scan #(.NREQ(NREQ), .NBASE(NBASE), .WIDTH(WIDTH)) u_scan (
        .valid  (req_valid),
        .sel    (req_base),
        .inc    (req_inc),
        .offset (offset),
        .total  (total)
    );

    psum_bank #(.NBASE(NBASE), .WIDTH(WIDTH)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mst_wr_en),
        .wr_idx  (mst_wr_idx),
        .wr_data (mst_wdata),
        .total   (total),
        .eff     (eff),
        .q       (base_q)
    );

    for (genvar b = 0; b < NBASE; b++) begin : g_unpack
        assign eff_arr[b] = eff[b*WIDTH +: WIDTH];
        assign q_arr[b]   = base_q[b*WIDTH +: WIDTH];
    end

    assign mst_rdata = q_arr[mst_rd_idx];

    for (genvar i = 0; i < NREQ; i++) begin : g_rsp
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rsp_valid[i]               <= 1'b0;
                rsp_old[i*WIDTH +: WIDTH]  <= '0;
            end else begin
                rsp_valid[i]               <= req_valid[i];
                rsp_old[i*WIDTH +: WIDTH]  <= eff_arr[req_base[i*IW +: IW]]
                                              + offset[i*WIDTH +: WIDTH];
            end
        end
    end
endmodule

// File: rtl/psum_unit_chk.sv
module psum_unit_chk #(
    parameter int NREQ  = 8,
    parameter int NBASE = 4,
    parameter int WIDTH = 32,
    localparam int IW   = (NBASE > 1) ? $clog2(NBASE) : 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NREQ-1:0]        req_valid,
    input logic [NREQ*IW-1:0]     req_base,
    input logic [NREQ*WIDTH-1:0]  req_inc,
    input logic                   mst_wr_en,
    input logic [IW-1:0]          mst_wr_idx,
    input logic [WIDTH-1:0]       mst_wdata,
    input logic [NREQ-1:0]        rsp_valid,
    input logic [NREQ*WIDTH-1:0]  rsp_old,
    input logic [NBASE*WIDTH-1:0] base_q
);
    function automatic logic [WIDTH-1:0] word_at(input logic [NBASE*WIDTH-1:0] v,
                                                 input logic [IW-1:0] k);
        return v[int'(k)*WIDTH +: WIDTH];
    endfunction

    logic [IW-1:0]    sel0;
    logic [WIDTH-1:0] base_of_r0;
    assign sel0       = req_base[IW-1:0];
    assign base_of_r0 = word_at(base_q, sel0);

    // R6: result strobe mirrors the request strobe one clock later
    a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rsp_valid == $past(req_valid)));

    // R6 / R2: no requests and no load leave every accumulator unchanged
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|req_valid) && !mst_wr_en) |=> (base_q == $past(base_q)));

    // R3: lowest-index requester sees the untouched accumulator
    a_r3_lowest_sees_base: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid[0] && !mst_wr_en) |=> (rsp_old[WIDTH-1:0] == $past(base_of_r0)));

    // R4: a single request adds exactly its increment
    a_r4_single_add: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_valid == NREQ'(1)) && !mst_wr_en) |=>
        (word_at(base_q, $past(sel0)) == $past(base_of_r0) + $past(req_inc[WIDTH-1:0])));

    // R8: a load with no requests lands exactly
    a_r8_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_wr_en && !(|req_valid)) |=>
        (word_at(base_q, $past(mst_wr_idx)) == $past(mst_wdata)));
endmodule

bind psum_unit psum_unit_chk #(.NREQ(NREQ), .NBASE(NBASE), .WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_base   (req_base),
    .req_inc    (req_inc),
    .mst_wr_en  (mst_wr_en),
    .mst_wr_idx (mst_wr_idx),
    .mst_wdata  (mst_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_old    (rsp_old),
    .base_q     (base_q)
);

// File: tb/psum_unit_test.sv
`timescale 1ns/1ps
module psum_unit_test;
    localparam int NREQ  = 8;
    localparam int NBASE = 4;
    localparam int W     = 32;
    localparam int IW    = 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NREQ-1:0]   req_valid;
    logic [NREQ*IW-1:0] req_base;
    logic [NREQ*W-1:0] req_inc;
    logic              mst_wr_en;
    logic [IW-1:0]     mst_wr_idx;
    logic [W-1:0]      mst_wdata;
    logic [IW-1:0]     mst_rd_idx;
    logic [W-1:0]      mst_rdata;
    logic [NREQ-1:0]   rsp_valid;
    logic [NREQ*W-1:0] rsp_old;

    always #4 clk = ~clk;

    psum_unit #(.NREQ(NREQ), .NBASE(NBASE), .WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_base(req_base),
        .req_inc(req_inc), .mst_wr_en(mst_wr_en), .mst_wr_idx(mst_wr_idx),
        .mst_wdata(mst_wdata), .mst_rd_idx(mst_rd_idx), .mst_rdata(mst_rdata),
        .rsp_valid(rsp_valid), .rsp_old(rsp_old)
    );

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;
    logic [W-1:0] model [NBASE];

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_bases(input string tag);
        for (int b = 0; b < NBASE; b++) begin
            mst_rd_idx = IW'(b);
            #0.5;
            chk(mst_rdata == model[b], $sformatf("R9 %s base%0d", tag, b), mst_rdata, model[b]);
        end
    endtask

    task automatic run_cycle(input logic [NREQ-1:0] m, input logic [NREQ*IW-1:0] s,
                             input logic [NREQ*W-1:0] inc, input logic we,
                             input logic [IW-1:0] wi, input logic [W-1:0] wd,
                             input string tag);
        logic [W-1:0] exp_old [NREQ];
        logic [W-1:0] nxt [NBASE];
        @(negedge clk);
        req_valid = m; req_base = s; req_inc = inc;
        mst_wr_en = we; mst_wr_idx = wi; mst_wdata = wd;
        for (int b = 0; b < NBASE; b++) nxt[b] = model[b];
        if (we) nxt[wi] = wd;
        for (int i = 0; i < NREQ; i++) begin
            exp_old[i] = '0;
            if (m[i]) begin
                exp_old[i] = nxt[s[i*IW +: IW]];
                nxt[s[i*IW +: IW]] = nxt[s[i*IW +: IW]] + inc[i*W +: W];
            end
        end
        @(posedge clk);
        #1;
        req_valid = '0; mst_wr_en = 1'b0;
        chk(rsp_valid == m, $sformatf("R6 %s rsp_valid", tag), W'(rsp_valid), W'(m));
        for (int i = 0; i < NREQ; i++) begin
            if (m[i]) chk(rsp_old[i*W +: W] == exp_old[i],
                          $sformatf("%s req%0d old", tag, i), rsp_old[i*W +: W], exp_old[i]);
        end
        for (int b = 0; b < NBASE; b++) model[b] = nxt[b];
        check_bases(tag);
    endtask

    initial begin
        #(8.0 * 190000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [NREQ*IW-1:0] s;
        logic [NREQ*W-1:0]  inc;
        rst_n = 1'b0; req_valid = '0; req_base = '0; req_inc = '0;
        mst_wr_en = 1'b0; mst_wr_idx = '0; mst_wdata = '0; mst_rd_idx = '0;
        for (int b = 0; b < NBASE; b++) model[b] = '0;
        repeat (3) @(posedge clk);
        #1;
        chk(rsp_valid == '0, "R1 rsp_valid in reset", W'(rsp_valid), '0);
        check_bases("R1 in reset");
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check_bases("R1 after reset");

        // R2: single request
        s = '0; s[0 +: IW] = 2'd1; inc = '0; inc[0 +: W] = 32'd5;
        run_cycle(8'h01, s, inc, 1'b0, '0, '0, "R2 single");
        inc[0 +: W] = 32'd7;
        run_cycle(8'h01, s, inc, 1'b0, '0, '0, "R2 repeat");

        // R3 R4: all eight to accumulator 2
        for (int i = 0; i < NREQ; i++) begin
            s[i*IW +: IW] = 2'd2; inc[i*W +: W] = W'(i + 1);
        end
        run_cycle(8'hFF, s, inc, 1'b0, '0, '0, "R3 R4 all-to-one");

        // R6: inactive requesters carry nonzero increments
        run_cycle(8'h5A, s, inc, 1'b0, '0, '0, "R6 partial mask");

        // R7: wrap
        for (int i = 0; i < NREQ; i++) begin
            s[i*IW +: IW] = 2'd0; inc[i*W +: W] = 32'h0000_0010;
        end
        run_cycle(8'h00, s, inc, 1'b1, 2'd0, 32'hFFFF_FFF0, "R8 load only");
        run_cycle(8'h03, s, inc, 1'b0, '0, '0, "R7 wrap");

        // R8: load and requests to same accumulator in one cycle
        run_cycle(8'h81, s, inc, 1'b1, 2'd0, 32'h1234_0000, "R8 load+req");
        // R8 R5: load one accumulator while requests hit another
        for (int i = 0; i < NREQ; i++) s[i*IW +: IW] = 2'd3;
        run_cycle(8'h0F, s, inc, 1'b1, 2'd1, 32'hABCD_0000, "R8 R5 load other");

        // R5 R3 R6: sweep over every mask with varied mappings
        for (int p = 0; p < 256; p++) begin
            for (int i = 0; i < NREQ; i++) begin
                s[i*IW +: IW]  = IW'((i * (p % 3 + 1) + p / 16) % NBASE);
                inc[i*W +: W]  = W'(p * 7 + i * 13 + 1) ^ (W'(p) << 24);
            end
            run_cycle(NREQ'(p), s, inc, (p % 37) == 5, IW'(p), W'(p * 1000),
                      "R5 R3 sweep");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule